// File: doc/BRIEF.md
# Machine-Check Response Controller

This block sits beside a 32-bit processor core and decides what the core does when a machine-check error is reported. A one-cycle error strobe arrives with a flag that marks the error as an instruction-fetch or a load/store error, the effective address of the faulting instruction, and the current machine state register. The controller weighs the machine-check enable bit of that register, a debug flag captured when reset is released, and two debug-enable bits. From these it picks one of three outcomes: branch to the machine-check handler, halt in checkstop, or enter debug mode.

On the handler outcome it loads the two save/restore registers. The first holds the faulting address. The second is a field-by-field image of the machine state register with the error type folded in. Checkstop halts the core until the next reset, and its entry sends a one-cycle indication to the reset unit. Debug mode lasts until the debug side releases it. While the core is halted or in debug mode, a new error is ignored.

Bits are numbered big-endian throughout: bit 0 is the most significant bit of a 32-bit register, so bit n sits at vector index 31-n. The machine-check enable bit is machine-state bit 19, at index 12.

Top module: `mce_ctrl`

## Requirements
- R1: `action_o` is one-hot, with 3'b001 for the handler, 3'b010 for checkstop and 3'b100 for debug mode. It is non-zero only in the single cycle after an accepted error strobe, and zero in every other cycle.
- R2: With the captured debug flag at 0, the machine-check enable bit (`msr_i[12]`) decides alone: 0 gives checkstop and 1 gives the handler. Both debug-enable bits are ignored.
- R3: With the captured debug flag at 1 and the machine-check enable bit at 0, `chk_dbg_en_i` decides: 0 gives checkstop and 1 gives debug mode. `mc_dbg_en_i` is ignored.
- R4: With the captured debug flag at 1 and the machine-check enable bit at 1, `mc_dbg_en_i` decides: 0 gives the handler and 1 gives debug mode. `chk_dbg_en_i` is ignored.
- R5: `dbg_boot_i` is sampled at the first rising clock edge after `rst_ni` deasserts. That value governs every later error until the next reset, and later changes to the pin have no effect.
- R6: After a checkstop outcome, `checkstop_o` stays at 1 until reset, and any further error strobe produces no outcome and leaves the save/restore registers unchanged.
- R7: `rst_req_o` pulses high for exactly one cycle, in the same cycle that `action_o` reports checkstop.
- R8: On the handler outcome, `srr0_o` holds `err_addr_i` from the strobe cycle, starting in the cycle after the strobe.
- R9: On the handler outcome, `srr1_o` is formed from the fields of `msr_i`:
  - bit 0 is cleared;
  - bit 1 is 1 for a fetch error (`err_fetch_i`=1) and 0 for a load/store error;
  - bits 2:4 and 10:15 are cleared;
  - bits 5:9 and 16:31 are copied from `msr_i`, so bit 30 follows the register's bit 30.
  
  As a mask, this is `(msr_i & 32'h07C0FFFF) | (err_fetch_i << 30)`.
- R10: The save/restore registers are written only on the handler outcome. Checkstop and debug outcomes leave them at their previous values.
- R11: In debug mode, `debug_o` is 1 and error strobes are ignored. A `dbg_release_i` pulse returns the core to the running state, after which errors are accepted again.
- R12: During reset, `action_o`, `srr0_o`, `srr1_o`, `checkstop_o`, `debug_o` and `rst_req_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| err_valid_i | input | 1 | One-cycle machine-check error strobe |
| err_fetch_i | input | 1 | 1 = instruction-fetch error, 0 = load/store error |
| err_addr_i | input | 32 | Effective address of the faulting instruction |
| msr_i | input | 32 | Current machine state register |
| dbg_boot_i | input | 1 | Debug-enable flag, captured as reset ends |
| chk_dbg_en_i | input | 1 | Send checkstop cases to debug mode |
| mc_dbg_en_i | input | 1 | Send handler cases to debug mode |
| dbg_release_i | input | 1 | Leave debug mode |
| action_o | output | 3 | One-hot outcome, valid the cycle after the strobe |
| srr0_o | output | 32 | Save/restore register 0 |
| srr1_o | output | 32 | Save/restore register 1 |
| checkstop_o | output | 1 | Core halted until reset |
| debug_o | output | 1 | Core in debug mode |
| rst_req_o | output | 1 | One-cycle checkstop indication to the reset unit |

## Verification
The bench covers every combination of the captured debug flag, the enable bit and the two debug bits. A decoder that read the wrong debug bit, or one that honoured a bit that should be ignored, would report the wrong outcome for at least one of those rows.

Several directed cases follow:
- The debug pin is flipped after reset. A design that kept tracking the pin would change its decision.
- A second error is sent into checkstop and into debug mode. A design that re-armed would report a fresh outcome or overwrite the save/restore registers.
- The second save/restore register is loaded with an all-ones and a patterned state word under both error types. A swapped bit order or a wrong mask shows up there.

// File: rtl/mce_pkg.sv
package mce_pkg;
  localparam int unsigned XLEN = 32;

  typedef enum logic [2:0] {
    ACT_NONE = 3'b000,
    ACT_HNDL = 3'b001,
    ACT_CHK  = 3'b010,
    ACT_DBG  = 3'b100
  } act_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_CHK  = 2'd1,
    ST_DBG  = 2'd2
  } core_st_e;

  // big-endian bit n of a register lives at vector index XLEN-1-n
  function automatic int unsigned be_idx(input int unsigned n);
    return XLEN - 1 - n;
  endfunction

  localparam int unsigned ME_BIT = 19;
  localparam int unsigned TYPE_BIT = 1;
endpackage

// File: rtl/mce_decide.sv
module mce_decide
  import mce_pkg::*;
(
  input  logic dbg_i,
  input  logic me_i,
  input  logic chk_dbg_i,
  input  logic mc_dbg_i,
  output act_e act_o
);
  always_comb begin
    if (!dbg_i)      act_o = me_i ? ACT_HNDL : ACT_CHK;
    else if (!me_i)  act_o = chk_dbg_i ? ACT_DBG : ACT_CHK;
    else             act_o = mc_dbg_i ? ACT_DBG : ACT_HNDL;
  end

  always_comb begin
    a_r1_onehot_decide: assert ($onehot(act_o));
  end
endmodule

// File: rtl/mce_save_regs.sv
module mce_save_regs
  import mce_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         fetch_i,
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] msr_i,
  output logic [W-1:0] srr0_o,
  output logic [W-1:0] srr1_o
);
  // keep-mask: big-endian bits 5:9 and 16:31 pass through from the state word
  localparam logic [W-1:0] KEEP = keep_mask();

  function automatic logic [W-1:0] keep_mask();
    logic [W-1:0] m;
    m = '0;
    for (int n = 5; n <= 9; n++) m[be_idx(n)] = 1'b1;
    for (int n = 16; n < int'(W); n++) m[be_idx(n)] = 1'b1;
    return m;
  endfunction

  logic [W-1:0] srr1_d;

  always_comb begin
    srr1_d = msr_i & KEEP;
    srr1_d[be_idx(TYPE_BIT)] = fetch_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srr0_o <= '0;
      srr1_o <= '0;
    end else if (load_i) begin
      srr0_o <= addr_i;
      srr1_o <= srr1_d;
    end
  end

  a_r10_hold_unloaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(srr0_o) && $stable(srr1_o)));
  a_r9_srr1_top_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (srr1_o[be_idx(0)] == 1'b0 && srr1_o[be_idx(2)] == 1'b0));
endmodule

// File: rtl/mce_state.sv
module mce_state
  import mce_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_i,
  input  act_e dec_i,
  input  logic release_i,
  output logic accept_o,
  output act_e act_o,
  output logic chk_o,
  output logic dbg_o,
  output logic rst_req_o
);
  core_st_e st_q, st_d;

  assign accept_o = err_i && (st_q == ST_RUN);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN: if (accept_o) begin
        if (dec_i == ACT_CHK)      st_d = ST_CHK;
        else if (dec_i == ACT_DBG) st_d = ST_DBG;
      end
      ST_DBG: if (release_i) st_d = ST_RUN;
      ST_CHK: st_d = ST_CHK;  // only reset leaves
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_RUN;
      act_o     <= ACT_NONE;
      rst_req_o <= 1'b0;
    end else begin
      st_q      <= st_d;
      act_o     <= accept_o ? dec_i : ACT_NONE;
      rst_req_o <= accept_o && (dec_i == ACT_CHK);
    end
  end

  assign chk_o = (st_q == ST_CHK);
  assign dbg_o = (st_q == ST_DBG);

  a_r6_chk_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_o |=> chk_o);
  a_r6_chk_no_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_o && err_i) |=> (act_o == ACT_NONE));
  a_r11_dbg_no_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_o && err_i) |=> (act_o == ACT_NONE));
  a_r7_req_with_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (act_o == ACT_CHK && chk_o));
  a_r7_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  a_r1_act_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o != ACT_NONE) |=> (act_o == ACT_NONE || $past(err_i)));
endmodule

// File: rtl/mce_ctrl.sv
module mce_ctrl
  import mce_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        err_valid_i,
  input  logic        err_fetch_i,
  input  logic [31:0] err_addr_i,
  input  logic [31:0] msr_i,
  input  logic        dbg_boot_i,
  input  logic        chk_dbg_en_i,
  input  logic        mc_dbg_en_i,
  input  logic        dbg_release_i,
  output logic [2:0]  action_o,
  output logic [31:0] srr0_o,
  output logic [31:0] srr1_o,
  output logic        checkstop_o,
  output logic        debug_o,
  output logic        rst_req_o
);
  logic armed_q, dbg_q, dbg_eff, accept;
  act_e dec, act_q;

  // capture the debug flag on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      dbg_q   <= 1'b0;
    end else if (!armed_q) begin
      armed_q <= 1'b1;
      dbg_q   <= dbg_boot_i;
    end
  end

  assign dbg_eff = armed_q ? dbg_q : dbg_boot_i;

  mce_decide u_decide (
    .dbg_i     (dbg_eff),
    .me_i      (msr_i[be_idx(ME_BIT)]),
    .chk_dbg_i (chk_dbg_en_i),
    .mc_dbg_i  (mc_dbg_en_i),
    .act_o     (dec)
  );

  mce_state u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .err_i     (err_valid_i),
    .dec_i     (dec),
    .release_i (dbg_release_i),
    .accept_o  (accept),
    .act_o     (act_q),
    .chk_o     (checkstop_o),
    .dbg_o     (debug_o),
    .rst_req_o (rst_req_o)
  );

  mce_save_regs #(.W(32)) u_save (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept && dec == ACT_HNDL),
    .fetch_i (err_fetch_i),
    .addr_i  (err_addr_i),
    .msr_i   (msr_i),
    .srr0_o  (srr0_o),
    .srr1_o  (srr1_o)
  );

  assign action_o = act_q;

  a_r5_flag_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> $stable(dbg_q));
  a_r2_nodbg_me0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !dbg_eff && !msr_i[12]) |=> (action_o == 3'b010));
  a_r2_nodbg_me1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !dbg_eff && msr_i[12]) |=> (action_o == 3'b001));
  a_r3_dbg_me0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && dbg_eff && !msr_i[12]) |=> (action_o == (chk_dbg_en_i ? 3'b100 : 3'b010)));
  a_r4_dbg_me1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && dbg_eff && msr_i[12]) |=> (action_o == (mc_dbg_en_i ? 3'b100 : 3'b001)));
  a_r8_srr0_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && dec == ACT_HNDL) |=> (srr0_o == $past(err_addr_i)));
  a_r1_out_onehot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(action_o));
endmodule

// File: tb/mce_ctrl_test.sv
module mce_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        err_valid_i = 1'b0, err_fetch_i = 1'b0;
  logic [31:0] err_addr_i = '0, msr_i = '0;
  logic        dbg_boot_i = 1'b0, chk_dbg_en_i = 1'b0, mc_dbg_en_i = 1'b0, dbg_release_i = 1'b0;
  logic [2:0]  action_o;
  logic [31:0] srr0_o, srr1_o;
  logic        checkstop_o, debug_o, rst_req_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  mce_ctrl uut (.*);

  localparam logic [2:0] H = 3'b001, C = 3'b010, D = 3'b100;
  // {dbg, me, chk_dbg, mc_dbg, expected action}
  localparam logic [6:0] VEC [16] = '{
    {4'b0000, C}, {4'b0010, C}, {4'b0001, C}, {4'b0011, C},
    {4'b0100, H}, {4'b0110, H}, {4'b0101, H}, {4'b0111, H},
    {4'b1000, C}, {4'b1001, C}, {4'b1010, D}, {4'b1011, D},
    {4'b1100, H}, {4'b1110, H}, {4'b1101, D}, {4'b1111, D}
  };

  function automatic logic [31:0] exp_srr1(input logic [31:0] m, input logic f);
    return (m & 32'h07C0FFFF) | ({31'd0, f} << 30);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic dbg);
    @(negedge clk_i);
    rst_ni = 1'b0; dbg_boot_i = dbg;
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    dbg_boot_i = ~dbg;  // later changes must not matter (R5)
    @(negedge clk_i);
  endtask

  // strobe one error; returns sampled action the cycle after
  task automatic strobe(input logic fetch, input logic [31:0] addr, output logic [2:0] act);
    err_valid_i = 1'b1; err_fetch_i = fetch; err_addr_i = addr;
    @(negedge clk_i);
    err_valid_i = 1'b0;
    act = action_o;
  endtask

  initial begin
    logic [2:0] a;
    // R12 reset state
    rst_ni = 1'b0;
    #3;
    check("R12", {26'd0, action_o, checkstop_o, debug_o, rst_req_o}, 32'd0);
    check("R12", srr0_o | srr1_o, 32'd0);

    // table walk over the decision inputs: R2 R3 R4 R5
    for (int i = 0; i < 16; i++) begin
      logic [2:0] exp;
      exp = VEC[i][2:0];
      do_reset(VEC[i][6]);
      msr_i = VEC[i][5] ? 32'h0000_1000 : 32'h0;
      chk_dbg_en_i = VEC[i][4]; mc_dbg_en_i = VEC[i][3];
      strobe(1'b0, 32'h1000_0000 + i, a);
      check(VEC[i][6] ? (VEC[i][5] ? "R4" : "R3") : "R2", {29'd0, a}, {29'd0, exp});
      check("R7", {31'd0, rst_req_o}, {31'd0, exp == C});
      // R10: no write unless handler
      check("R10", srr0_o, exp == H ? 32'h1000_0000 + i : 32'd0);
      @(negedge clk_i);
      check("R1", {29'd0, action_o}, 32'd0);
      check("R7", {31'd0, rst_req_o}, 32'd0);
    end

    // R8 R9: handler loads, fetch error, all-ones state
    do_reset(1'b0);
    msr_i = 32'hFFFF_FFFF;
    strobe(1'b1, 32'hDEAD_BEE0, a);
    check("R8", srr0_o, 32'hDEAD_BEE0);
    check("R9", srr1_o, exp_srr1(32'hFFFF_FFFF, 1'b1));
    // R9: load/store error, patterned state with bit 30 clear
    msr_i = 32'hA5A5_5A5D;
    strobe(1'b0, 32'h0000_0404, a);
    check("R9", srr1_o, exp_srr1(32'hA5A5_5A5D, 1'b0));
    check("R8", srr0_o, 32'h0000_0404);

    // R6: checkstop sticky, later errors ignored
    do_reset(1'b0);
    msr_i = 32'h0;
    strobe(1'b0, 32'h11, a);
    check("R6", {31'd0, checkstop_o}, 32'd1);
    msr_i = 32'h0000_1000;  // would be handler if accepted
    strobe(1'b1, 32'h22, a);
    check("R6", {29'd0, a}, 32'd0);
    check("R6", srr0_o, 32'd0);
    repeat (5) @(negedge clk_i);
    check("R6", {31'd0, checkstop_o}, 32'd1);

    // R11: debug mode ignores errors, release re-arms
    do_reset(1'b1);
    msr_i = 32'h0; chk_dbg_en_i = 1'b1;
    strobe(1'b0, 32'h33, a);
    check("R11", {30'd0, debug_o, checkstop_o}, 32'd2);
    msr_i = 32'h0000_1000; mc_dbg_en_i = 1'b0;
    strobe(1'b0, 32'h44, a);
    check("R11", {29'd0, a}, 32'd0);
    check("R11", srr0_o, 32'd0);
    dbg_release_i = 1'b1;
    @(negedge clk_i);
    dbg_release_i = 1'b0;
    check("R11", {31'd0, debug_o}, 32'd0);
    strobe(1'b0, 32'h55, a);
    check("R11", {29'd0, a}, {29'd0, H});
    check("R8", srr0_o, 32'h55);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule